// File: doc/BRIEF.md
# Gray-Pointer Dual-Port Delay Buffer

This block is a first-in first-out delay buffer that parks butterfly difference results until the pipeline needs them again. It stores words in one dual-port RAM. Its write side and its read side each keep their own pointer. Every pointer is a Gray-code register with a binary shadow: the binary value addresses the RAM, and the Gray value is what the two sides compare. An external sequencer pulses the write-increment to store a word and the read-increment to fetch the oldest word. Reads return data one cycle later through a registered read port.

Each pointer carries one bit more than the RAM address. This lets a completely full buffer be told apart from an empty one. The full flag comes from the next Gray write value, with its two top bits inverted, compared against the next Gray read value. The empty flag comes from equality of the two next Gray values. Both flags are registered. The whole block runs on one clock.

Top module: `gray_delay_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0 and `rd_data` is 0.
- R2: Words come out in the order they were written. A read accepted at a clock edge presents its word on `rd_data` directly after that edge.
- R3: `full` is 1 exactly when the buffer holds 2**ADDR_W words, and it rises directly after the edge that stores the last such word.
- R4: A write requested while `full` is 1 is dropped. No later read returns the dropped word, and the occupancy does not change.
- R5: A read requested while `empty` is 1 is dropped. `rd_data` keeps its last value and the read pointer does not move. Whenever no read is accepted, `rd_data` holds.
- R6: `empty` is 1 exactly when the buffer holds no words. It falls directly after the edge that stores the first word.
- R7: A read and a write requested together while the buffer is neither empty nor full are both performed, and `full` and `empty` keep their values.
- R8: A read and a write requested together while the buffer is full perform only the read. The oldest word is returned and `full` falls.
- R9: Across many passes around the RAM, pointer wrap-around keeps ordering and both flags correct. Each Gray pointer changes in at most one bit per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_inc | input | 1 | Store `wr_data` and advance the write pointer |
| wr_data | input | DATA_W | Word to store |
| rd_inc | input | 1 | Fetch the oldest word and advance the read pointer |
| rd_data | output | DATA_W | Fetched word, valid the cycle after an accepted read |
| full | output | 1 | Buffer holds 2**ADDR_W words |
| empty | output | 1 | Buffer holds no words |

## Verification
The bench first fills the buffer to the brim, then pushes writes against a full buffer and reads against an empty one. A design that ignored the flags would overwrite the oldest word, or would replay stale data and leave its pointers skewed, and every later word would come out wrong.

It also drives simultaneous read and write, both in the middle of the range and at full. A wrong two-bit inversion in the full compare would raise `full` at half depth or never raise it. A blocked read at full would stall the pipeline.

A long mixed pattern wraps both pointers several times. An off-by-one in the Gray/binary conversion would only show up on the second lap.

// File: rtl/fifo_gray_pkg.sv
package fifo_gray_pkg;
  localparam int CONV_W = 32;

  // Gray word to binary: each bit is the XOR of all Gray bits above and including it
  function automatic logic [CONV_W-1:0] gray_to_bin(input logic [CONV_W-1:0] g);
    logic [CONV_W-1:0] b;
    b[CONV_W-1] = g[CONV_W-1];
    for (int i = CONV_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [CONV_W-1:0] bin_to_gray(input logic [CONV_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // Mask that flips the two top bits of an n-bit Gray pointer
  function automatic logic [CONV_W-1:0] wrap_flip(input int n);
    return CONV_W'(3) << (n - 2);
  endfunction
endpackage

// File: rtl/gray_ptr_ctr.sv
module gray_ptr_ctr
  import fifo_gray_pkg::*;
#(
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [PTR_W-1:0] gray_q,
  output logic [PTR_W-1:0] bin_cur,
  output logic [PTR_W-1:0] bin_nxt,
  output logic [PTR_W-1:0] gray_nxt
);
  logic [CONV_W-1:0] bin_wide;

  assign bin_wide = gray_to_bin(CONV_W'(gray_q));
  assign bin_cur  = bin_wide[PTR_W-1:0];
  assign bin_nxt  = bin_cur + PTR_W'(inc);
  assign gray_nxt = PTR_W'(bin_to_gray(CONV_W'(bin_nxt)));

  always_ff @(posedge clk) begin
    if (!rst_n) gray_q <= '0;
    else        gray_q <= gray_nxt;
  end
endmodule

// File: rtl/dp_ram_reg.sv
module dp_ram_reg #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/gray_delay_fifo.sv
module gray_delay_fifo
  import fifo_gray_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_inc,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_inc,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] FLIP = PTR_W'(wrap_flip(PTR_W));

  logic             full_q, empty_q;
  logic             wr_fire, rd_fire;
  logic [PTR_W-1:0] wg_q, wb_cur, wb_nxt, wg_nxt;
  logic [PTR_W-1:0] rg_q, rb_cur, rb_nxt, rg_nxt;
  logic [PTR_W-1:0] full_word;
  logic             full_next, empty_next;

  // Accepted transfers, visible to the checker
  assign wr_fire = wr_inc & ~full_q;
  assign rd_fire = rd_inc & ~empty_q;

  gray_ptr_ctr #(.PTR_W(PTR_W)) u_wptr (
    .clk(clk), .rst_n(rst_n), .inc(wr_fire),
    .gray_q(wg_q), .bin_cur(wb_cur), .bin_nxt(wb_nxt), .gray_nxt(wg_nxt)
  );

  gray_ptr_ctr #(.PTR_W(PTR_W)) u_rptr (
    .clk(clk), .rst_n(rst_n), .inc(rd_fire),
    .gray_q(rg_q), .bin_cur(rb_cur), .bin_nxt(rb_nxt), .gray_nxt(rg_nxt)
  );

  dp_ram_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .we(wr_fire), .waddr(wb_cur[ADDR_W-1:0]), .wdata(wr_data),
    .re(rd_fire), .raddr(rb_cur[ADDR_W-1:0]), .rdata(rd_data)
  );

  // Full: next write Gray with two top bits flipped meets next read Gray
  assign full_word  = wg_nxt ^ FLIP;
  assign full_next  = (full_word == rg_nxt);
  assign empty_next = (rg_nxt == wg_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      full_q  <= full_next;
      empty_q <= empty_next;
    end
  end

  assign full  = full_q;
  assign empty = empty_q;
endmodule

// File: rtl/gray_delay_fifo_chk.sv
module gray_delay_fifo_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_inc,
  input logic              rd_inc,
  input logic              wr_fire,
  input logic              rd_fire,
  input logic              full,
  input logic              empty,
  input logic [ADDR_W:0]   wg_q,
  input logic [ADDR_W:0]   rg_q,
  input logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W+1:0] occ;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + (ADDR_W+2)'(wr_fire) - (ADDR_W+2)'(rd_fire);
  end

  a_r3_full_matches_occ: assert property (@(posedge clk) disable iff (!rst_n)
    full == (occ == (ADDR_W+2)'(DEPTH)));
  a_r6_empty_matches_occ: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (occ == '0));
  a_r4_wptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_inc) |=> $stable(wg_q));
  a_r5_rptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_inc) |=> $stable(rg_q));
  a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rd_data));
  a_r7_flags_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd_fire) |=> ($stable(full) && $stable(empty)));
  a_r8_full_read_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rd_inc) |=> !full);
  a_r9_wgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wg_q ^ $past(wg_q)) <= 1);
  a_r9_rgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rg_q ^ $past(rg_q)) <= 1);
endmodule

bind gray_delay_fifo gray_delay_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_inc(wr_inc), .rd_inc(rd_inc),
  .wr_fire(wr_fire), .rd_fire(rd_fire), .full(full), .empty(empty),
  .wg_q(wg_q), .rg_q(rg_q), .rd_data(rd_data)
);

// File: tb/gray_delay_fifo_test.sv
module gray_delay_fifo_test;
  localparam int DW    = 16;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_inc = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_inc = 1'b0;
  logic [DW-1:0] rd_data;
  logic          full, empty;

  logic [DW-1:0] model_q[$];
  logic [DW-1:0] exp_rd = '0;
  int vectors = 0;
  int errors  = 0;

  always #5 clk = ~clk;

  gray_delay_fifo #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_inc(wr_inc), .wr_data(wr_data),
    .rd_inc(rd_inc), .rd_data(rd_data), .full(full), .empty(empty)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One cycle, entered and left at a falling edge; checks all outputs
  task automatic step(input logic w, input logic [DW-1:0] d, input logic r, input string req);
    bit wacc = w && (model_q.size() < DEPTH);
    bit racc = r && (model_q.size() > 0);
    wr_inc = w; wr_data = d; rd_inc = r;
    if (racc) exp_rd = model_q.pop_front();
    if (wacc) model_q.push_back(d);
    @(posedge clk);
    @(negedge clk);
    wr_inc = 1'b0; rd_inc = 1'b0;
    check(req, "full",    32'(full),    32'(model_q.size() == DEPTH));
    check(req, "empty",   32'(empty),   32'(model_q.size() == 0));
    check(req, "rd_data", 32'(rd_data), 32'(exp_rd));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", "full",    32'(full),    32'd0);
    check("R1", "empty",   32'(empty),   32'd1);
    check("R1", "rd_data", 32'(rd_data), 32'd0);
  endtask

  task automatic t_first_word;
    step(1'b1, 16'hA5C3, 1'b0, "R6");
    step(1'b0, '0, 1'b1, "R2");
  endtask

  task automatic t_fill_overrun_drain;
    for (int i = 0; i < DEPTH; i++) step(1'b1, DW'(16'h1000 + i), 1'b0, "R3");
    step(1'b1, 16'hDEAD, 1'b0, "R4");
    step(1'b1, 16'hBEEF, 1'b0, "R4");
    for (int i = 0; i < DEPTH; i++) step(1'b0, '0, 1'b1, "R2");
    step(1'b0, '0, 1'b1, "R5");
    step(1'b0, '0, 1'b1, "R5");
    step(1'b1, 16'h7E57, 1'b0, "R5");
    step(1'b0, '0, 1'b1, "R5");
  endtask

  task automatic t_mid_simul;
    for (int i = 0; i < 3; i++) step(1'b1, DW'(16'h2200 + i), 1'b0, "R7");
    for (int i = 0; i < 10; i++) step(1'b1, DW'(16'h3300 + i), 1'b1, "R7");
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, "R7");
  endtask

  task automatic t_full_simul;
    for (int i = 0; i < DEPTH; i++) step(1'b1, DW'(16'h4400 + i), 1'b0, "R8");
    step(1'b1, 16'hFFFF, 1'b1, "R8");
    step(1'b1, 16'h4500, 1'b0, "R8");
    for (int i = 0; i < DEPTH; i++) step(1'b0, '0, 1'b1, "R8");
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 6 * DEPTH; i++)
      step((i % 3) != 2, DW'(16'h5000 + i), (i % 2) == 0 || i > 4 * DEPTH, "R9");
    while (model_q.size() > 0) step(1'b0, '0, 1'b1, "R9");
    step(1'b0, '0, 1'b1, "R9");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_first_word();
    t_fill_overrun_drain();
    t_mid_simul();
    t_full_simul();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule